// File: doc/BRIEF.md
# Quadrant-Folding Phase Accumulator

This block is the phase front end of a sine synthesizer that stores only one quarter of a sine period and interpolates between stored nodes. On every clock a wide phase register advances by a frequency word. A coarse phase offset is added to the register value to give the instantaneous phase. That phase is folded into the first quarter of the period: within a quadrant it is either passed through or mirrored about the quarter point. A sign flag tells the downstream amplitude stage whether to negate the result.

The folded phase is split into a node index in its upper bits and an intra-interval fraction in its lower bits. The block also supplies the index of the following node, so an interpolator can fetch both interval ends at once. All outputs come from one register stage, and a valid flag marks the first output that follows reset.

The output frequency is freq_word * f_clk / 2^ACC_W, so the accumulator wraps every 2^ACC_W / freq_word clocks.

Top module: `qfold_phase_gen`

## Requirements
- R1: While rst_n is low, node_idx, node_nxt, frac, sign_pos and out_valid are all 0, and the phase register is cleared.
- R2: On every clock the phase register adds freq_word modulo 2^ACC_W. A changed freq_word takes effect on the next clock, and the phase already reached is kept.
- R3: The instantaneous phase is the phase register plus ofs_word shifted left by ACC_W-OFS_W bits, modulo 2^ACC_W, so one offset step equals 2^(ACC_W-OFS_W) phase units.
- R4: The two top phase bits select the quadrant. In quadrants 0 (00) and 2 (10) the folded phase equals the lower ACC_W-2 bits p.
- R5: In quadrants 1 (01) and 3 (11) the folded phase is 2^(ACC_W-2) - p. When p is 0 this saturates at the quarter point: node_idx is 2^IDX_W and frac is 0, with IDX_W = ACC_W-2-FRAC_W.
- R6: sign_pos is 1 in quadrants 0 and 1 and 0 (negate) in quadrants 2 and 3.
- R7: node_idx is the folded phase shifted right by FRAC_W (width IDX_W+1). frac is its lower FRAC_W bits.
- R8: node_nxt is node_idx + 1, except that it stays at 2^IDX_W when node_idx is already 2^IDX_W.
- R9: out_valid rises on the first clock after rst_n is released and stays high until the next reset.
- R10: The outputs after clock edge k reflect the phase register value held before edge k, combined with ofs_word as sampled at edge k. This is one register of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| freq_word | input | ACC_W | Phase increment per clock |
| ofs_word | input | OFS_W | Coarse phase offset, MSB-aligned to the phase |
| node_idx | output | ACC_W-1-FRAC_W | Lower node index in the quarter table |
| node_nxt | output | ACC_W-1-FRAC_W | Upper node index, saturated at the quarter point |
| frac | output | FRAC_W | Position inside the node interval |
| sign_pos | output | 1 | 1 keeps the amplitude, 0 negates it |
| out_valid | output | 1 | Outputs carry a computed phase |

## Verification
The bench builds the block with ACC_W=32, OFS_W=14 and FRAC_W=20. This gives a 10-bit table index plus the quarter-point code 1024. At these values one offset step is 2^18 phase units, so an offset word with a zero-frequency word places the phase exactly on each quadrant boundary. The saturating mirror at the quarter point and the negative half can then be reached in a single cycle. Wraps of the 32-bit register are reached by near-full-scale frequency words, and mid-run frequency changes show that the phase reached is kept.

// File: rtl/qfold_pkg.sv
package qfold_pkg;

  typedef enum logic [1:0] {
    QD_RISE_POS = 2'b00,
    QD_FALL_POS = 2'b01,
    QD_FALL_NEG = 2'b10,
    QD_RISE_NEG = 2'b11
  } quadrant_e;

  // Mirrored quadrants run from the quarter point back toward zero.
  function automatic logic quad_mirrored(input quadrant_e q);
    return (q == QD_FALL_POS) || (q == QD_RISE_NEG);
  endfunction

  // The upper half of the cycle is emitted with a negate flag.
  function automatic logic quad_positive(input quadrant_e q);
    return (q == QD_RISE_POS) || (q == QD_FALL_POS);
  endfunction

endpackage

// File: rtl/qfold_phase_acc.sv
module qfold_phase_acc #(
  parameter int ACC_W = 32,
  parameter int OFS_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq_word,
  input  logic [OFS_W-1:0] ofs_word,
  output logic [ACC_W-1:0] inst_phase
);
  localparam int SHIFT = ACC_W - OFS_W;

  logic [ACC_W-1:0] acc_q;
  logic [ACC_W-1:0] acc_d;
  logic [ACC_W-1:0] ofs_aligned;

  always_comb begin
    acc_d = acc_q + freq_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else begin
      acc_q <= acc_d;
    end
  end

  generate
    if (SHIFT > 0) begin : g_pad
      assign ofs_aligned = {ofs_word, {SHIFT{1'b0}}};
    end else begin : g_full
      assign ofs_aligned = ofs_word[OFS_W-1 -: ACC_W];
    end
  endgenerate

  assign inst_phase = acc_q + ofs_aligned;

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> acc_q == $past(acc_q) + $past(freq_word)); // R2

endmodule

// File: rtl/qfold_mirror.sv
module qfold_mirror #(
  parameter int ACC_W = 32
) (
  input  logic [ACC_W-1:0] phase,
  output logic [ACC_W-2:0] folded,
  output logic             positive
);
  import qfold_pkg::*;

  localparam int Q_W = ACC_W - 2;

  quadrant_e        quad;
  logic [Q_W-1:0]   lower;
  logic [Q_W:0]     mirrored;

  always_comb begin
    quad     = quadrant_e'(phase[ACC_W-1 -: 2]);
    lower    = phase[Q_W-1:0];
    // inverting and adding one in Q_W+1 bits gives 2^Q_W - lower,
    // and lower == 0 lands exactly on the quarter point
    mirrored = {1'b0, ~lower} + {{Q_W{1'b0}}, 1'b1};
    if (quad_mirrored(quad)) begin
      folded = mirrored;
    end else begin
      folded = {1'b0, lower};
    end
    positive = quad_positive(quad);
  end

endmodule

// File: rtl/qfold_node_split.sv
module qfold_node_split #(
  parameter int ACC_W  = 32,
  parameter int FRAC_W = 20
) (
  input  logic [ACC_W-2:0]        folded,
  output logic [ACC_W-2-FRAC_W:0] idx,
  output logic [ACC_W-2-FRAC_W:0] idx_nxt,
  output logic [FRAC_W-1:0]       frac
);
  localparam int IDX_W  = ACC_W - 2 - FRAC_W;
  localparam int NODE_W = IDX_W + 1;
  localparam logic [NODE_W-1:0] IDX_TOP = NODE_W'(1) << IDX_W;

  always_comb begin
    idx  = folded[ACC_W-2 -: NODE_W];
    frac = folded[FRAC_W-1:0];
    if (idx == IDX_TOP) begin
      idx_nxt = IDX_TOP;
    end else begin
      idx_nxt = idx + NODE_W'(1);
    end
  end

endmodule

// File: rtl/qfold_phase_gen.sv
module qfold_phase_gen #(
  parameter int ACC_W  = 32,
  parameter int OFS_W  = 14,
  parameter int FRAC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ACC_W-1:0]        freq_word,
  input  logic [OFS_W-1:0]        ofs_word,
  output logic [ACC_W-2-FRAC_W:0] node_idx,
  output logic [ACC_W-2-FRAC_W:0] node_nxt,
  output logic [FRAC_W-1:0]       frac,
  output logic                    sign_pos,
  output logic                    out_valid
);
  localparam int IDX_W  = ACC_W - 2 - FRAC_W;
  localparam int NODE_W = IDX_W + 1;
  localparam logic [NODE_W-1:0] IDX_TOP = NODE_W'(1) << IDX_W;

  logic [ACC_W-1:0]  inst_phase;
  logic [ACC_W-2:0]  folded;
  logic              positive;
  logic [NODE_W-1:0] idx_d;
  logic [NODE_W-1:0] nxt_d;
  logic [FRAC_W-1:0] frac_d;

  qfold_phase_acc #(.ACC_W(ACC_W), .OFS_W(OFS_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .freq_word (freq_word),
    .ofs_word  (ofs_word),
    .inst_phase(inst_phase)
  );

  qfold_mirror #(.ACC_W(ACC_W)) u_mirror (
    .phase   (inst_phase),
    .folded  (folded),
    .positive(positive)
  );

  qfold_node_split #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) u_split (
    .folded (folded),
    .idx    (idx_d),
    .idx_nxt(nxt_d),
    .frac   (frac_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      node_idx  <= '0;
      node_nxt  <= '0;
      frac      <= '0;
      sign_pos  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      node_idx  <= idx_d;
      node_nxt  <= nxt_d;
      frac      <= frac_d;
      sign_pos  <= positive;
      out_valid <= 1'b1;
    end
  end

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> node_idx <= IDX_TOP); // R5

  AST_QPOINT_FRAC: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && node_idx == IDX_TOP) |-> frac == '0); // R5

  AST_NEXT_NODE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((node_nxt == node_idx + NODE_W'(1)) ||
                   (node_idx == IDX_TOP && node_nxt == IDX_TOP))); // R8

  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> out_valid); // R9

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |=> out_valid); // R9

endmodule

// File: tb/sim_qfold_phase_gen.sv
module sim_qfold_phase_gen;
  localparam int  ACC_W  = 32;
  localparam int  OFS_W  = 14;
  localparam int  FRAC_W = 20;
  localparam int  NODE_W = ACC_W - 1 - FRAC_W;
  localparam time TCLK   = 10ns;
  localparam int  OUT_W  = 2 * NODE_W + FRAC_W + 1;

  logic                clk = 1'b0;
  logic                rst_n;
  logic [ACC_W-1:0]    freq_word;
  logic [OFS_W-1:0]    ofs_word;
  logic [NODE_W-1:0]   node_idx;
  logic [NODE_W-1:0]   node_nxt;
  logic [FRAC_W-1:0]   frac;
  logic                sign_pos;
  logic                out_valid;

  int checks = 0;
  int fails  = 0;
  logic [ACC_W-1:0] m_acc;

  always #(TCLK / 2) clk = ~clk;

  qfold_phase_gen #(.ACC_W(ACC_W), .OFS_W(OFS_W), .FRAC_W(FRAC_W)) u0 (
    .clk(clk), .rst_n(rst_n), .freq_word(freq_word), .ofs_word(ofs_word),
    .node_idx(node_idx), .node_nxt(node_nxt), .frac(frac),
    .sign_pos(sign_pos), .out_valid(out_valid)
  );

  // {freq_word, ofs_word}
  localparam logic [ACC_W+OFS_W-1:0] VEC [12] = '{
    {32'h0123_4567, 14'h0000},
    {32'h1000_0000, 14'h0000},
    {32'h2AAA_AAAB, 14'h0100},
    {32'h3FFF_FFFF, 14'h0FFF},
    {32'h4000_0001, 14'h1000},
    {32'h0000_0001, 14'h2000},
    {32'h8000_0000, 14'h3000},
    {32'hFFFF_FFFF, 14'h3FFF},
    {32'h7FFF_FFFF, 14'h1234},
    {32'h0010_0000, 14'h2ABC},
    {32'hC000_0000, 14'h0001},
    {32'h0BAD_F00D, 14'h3001}
  };

  // Expected outputs from the requirements (R3..R8)
  function automatic logic [OUT_W-1:0] model(input logic [ACC_W-1:0] ph);
    longint unsigned p, f, idx, nxt, fr, top;
    logic q_hi, q_lo;
    q_hi = ph[ACC_W-1];
    q_lo = ph[ACC_W-2];
    p    = longint'(ph[ACC_W-3:0]);
    top  = 64'd1 << (ACC_W - 2);
    f    = q_lo ? (top - p) : p;
    idx  = f >> FRAC_W;
    fr   = f & ((64'd1 << FRAC_W) - 1);
    nxt  = (idx == (64'd1 << (ACC_W - 2 - FRAC_W))) ? idx : idx + 1;
    return {idx[NODE_W-1:0], nxt[NODE_W-1:0], fr[FRAC_W-1:0], ~q_hi};
  endfunction

  task automatic check(input string req, input logic [OUT_W:0] act,
                       input logic [OUT_W:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    freq_word = '0;
    ofs_word  = '0;
    m_acc = '0;
    @(negedge clk);
    @(negedge clk);
    check("R1", {node_idx, node_nxt, frac, sign_pos, out_valid}, '0);
    rst_n = 1'b1;
  endtask

  // Called at a negedge; one edge of latency (R10)
  task automatic step(input string req, input logic [ACC_W-1:0] fw,
                      input logic [OFS_W-1:0] ow);
    logic [OUT_W-1:0] e;
    freq_word = fw;
    ofs_word  = ow;
    e = model(m_acc + {ow, {(ACC_W - OFS_W){1'b0}}});
    m_acc = m_acc + fw;
    @(posedge clk);
    @(negedge clk);
    check(req, {node_idx, node_nxt, frac, sign_pos, out_valid}, {e, 1'b1});
  endtask

  task automatic expect_fixed(input string req, input logic [OUT_W-1:0] e);
    check(req, {node_idx, node_nxt, frac, sign_pos, out_valid}, {e, 1'b1});
  endtask

  initial begin
    rst_n = 1'b0;
    freq_word = '0;
    ofs_word  = '0;
    m_acc = '0;
    do_reset();
    // table walk: R2, R3, R4, R6, R7, R10
    for (int i = 0; i < 12; i++) begin
      step("R2/R3/R7 table", VEC[i][ACC_W+OFS_W-1:OFS_W], VEC[i][OFS_W-1:0]);
    end
    // R9: valid from the first edge after release
    do_reset();
    check("R9 before edge", {31'd0, out_valid}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    check("R9 after edge", {31'd0, out_valid}, 32'd1);
    // quarter point, quadrant 1: fold saturates (R5, R8)
    do_reset();
    step("R5 q1 boundary", '0, 14'h1000);
    expect_fixed("R5 q1 quarter", {11'd1024, 11'd1024, 20'd0, 1'b1});
    // quadrant 3 boundary also mirrored, negative (R5, R6)
    step("R6 q3 boundary", '0, 14'h3000);
    expect_fixed("R6 q3 quarter", {11'd1024, 11'd1024, 20'd0, 1'b0});
    // quadrant 2 start: passes through, negative (R4, R6)
    step("R4 q2 start", '0, 14'h2000);
    expect_fixed("R4 q2 zero", {11'd0, 11'd1, 20'd0, 1'b0});
    // last offset step of quadrant 0: p = 0x3FFC0000 (R4, R7, R8)
    step("R7 q0 end", '0, 14'h0FFF);
    expect_fixed("R8 q0 end", {11'd1023, 11'd1024, 20'hC0000, 1'b1});
    // first step into quadrant 1: mirror of 2^18 (R5)
    step("R5 q1 mirror", '0, 14'h1001);
    expect_fixed("R5 q1 mirror val", {11'd1023, 11'd1024, 20'hC0000, 1'b1});
    // frequency change mid-run keeps the phase (R2)
    do_reset();
    for (int i = 0; i < 5; i++) step("R2 run a", 32'h0765_4321, 14'h0000);
    for (int i = 0; i < 5; i++) step("R2 run b", 32'hF000_0001, 14'h0000);
    // wrap through the full range with an offset (R3)
    for (int i = 0; i < 8; i++) step("R3 wrap", 32'h6000_0003, 14'h2222);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule